// File: doc/BRIEF.md
# Decision-Based Impulse Noise Filter

This block cleans salt-and-pepper noise out of an 8-bit grayscale image one pixel at a time. Each cycle the surrounding logic can present a full 3x3 neighbourhood with a valid strobe. The block returns the corrected centre pixel, with its own valid strobe, a fixed number of cycles later. Line buffering and image framing happen outside the block.

Filtering is a decision made per pixel. A centre pixel that is not at either impulse level passes through unchanged. A centre pixel at 0 or 255 is treated as corrupted. It is replaced by the median of the neighbourhood values that are not themselves impulses. When the whole neighbourhood is made of impulse levels, the replacement is the integer mean of all nine values. The median comes from a fixed sorting network. Each value carries a tag that marks it as extreme, and the sort key is built so that tagged values fall to the top of the order.

Top module: `impulse_repair_filter`

## Requirements
- R1: A pixel is an impulse exactly when its value is 0 or 255. Window element i sits at bits [8i+7:8i] of `win_data`, and the centre pixel is element 4. Values 1 and 254 count as clean.
- R2: When the centre pixel is not an impulse, the output equals the centre pixel, whatever the other eight values are.
- R3: When the centre pixel is an impulse and at least one window value lies in 1..254, the output is the median of only those in-range values. For an odd count it is the middle value in ascending order.
- R4: When the number of in-range values is even, the output is the lower of the two middle values in ascending order, counting duplicates separately.
- R5: When all nine window values are 0 or 255, the output is the sum of the nine values divided by 9, truncated toward zero.
- R6: Every window accepted with `win_valid` high produces exactly one result with `pix_valid` high, exactly 3 clock cycles later. A new window can be accepted every cycle, and results leave in input order. A window presented with `win_valid` low produces no result.
- R7: A synchronous active-high `rst` clears every pipeline valid flag. `pix_valid` is low in the cycle after any reset edge, and no window that was in flight at the reset emerges afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| win_valid | input | 1 | The window on `win_data` is to be processed |
| win_data | input | 72 | Nine 8-bit pixels, element i at bits [8i+7:8i], centre is element 4 |
| pix_valid | output | 1 | `pix_out` holds a result |
| pix_out | output | 8 | Corrected centre pixel |

## Verification
The embedded assertions check several properties on every cycle. The sorted network outputs must ascend, with tagged extremes last. The count of clean values must agree with the tags. A clean centre must pass straight to the output, and a noisy centre that has clean neighbours must never produce an impulse value. The valid strobe must trail the input strobe by exactly three cycles and must drop after reset. Only the bench scenarios can show that the chosen value is the correct order statistic, including the lower-middle choice for even counts and duplicate values. They also show that the all-extreme mean is truncated correctly, and that back-to-back streams come out in order.

// File: rtl/impf_pkg.sv
package impf_pkg;
  localparam int unsigned PIX_W = 8;
  localparam int unsigned KEY_W = PIX_W + 1;

  typedef logic [PIX_W-1:0] pix_t;
  // sort key: extreme tag in the MSB so tagged values order after all clean ones
  typedef logic [KEY_W-1:0] key_t;

  function automatic logic is_impulse(input pix_t p);
    return (p == '0) || (p == '1);
  endfunction

  function automatic key_t make_key(input pix_t p);
    return {is_impulse(p), p};
  endfunction

  function automatic pix_t mean_div(input logic [31:0] total, input int unsigned n);
    return pix_t'(total / n);
  endfunction
endpackage

// File: rtl/impf_detect.sv
module impf_detect
  import impf_pkg::*;
#(
  parameter int unsigned WIN    = 9,
  parameter int unsigned CENTRE = 4,
  parameter int unsigned CNT_W  = $clog2(WIN + 1),
  parameter int unsigned SUM_W  = PIX_W + $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_in,
  input  pix_t             px [WIN],
  output logic             s1_valid,
  output key_t             s1_keys [WIN],
  output logic [CNT_W-1:0] s1_cnt,
  output logic [SUM_W-1:0] s1_sum,
  output pix_t             s1_centre,
  output logic             s1_noisy
);
  logic [CNT_W-1:0] cnt_c;
  logic [SUM_W-1:0] sum_c;

  always_comb begin
    cnt_c = '0;
    sum_c = '0;
    for (int i = 0; i < int'(WIN); i++) begin
      cnt_c = cnt_c + CNT_W'(!is_impulse(px[i]));
      sum_c = sum_c + SUM_W'(px[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= v_in;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(WIN); i++) s1_keys[i] <= make_key(px[i]);
    s1_cnt    <= cnt_c;
    s1_sum    <= sum_c;
    s1_centre <= px[CENTRE];
    s1_noisy  <= is_impulse(px[CENTRE]);
  end

  // tag vector brought out for the checks below
  logic [WIN-1:0] s1_tags;
  for (genvar g = 0; g < int'(WIN); g++) begin : g_tag
    assign s1_tags[g] = s1_keys[g][PIX_W];
  end

  a_r1_count_matches_tags: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> ($countones(s1_tags) + int'(s1_cnt)) == int'(WIN));
  a_r1_centre_flag: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> s1_noisy == s1_tags[CENTRE]);
endmodule

// File: rtl/impf_sort.sv
module impf_sort
  import impf_pkg::*;
#(
  parameter int unsigned WIN = 9
) (
  input  key_t keys_in  [WIN],
  output key_t keys_out [WIN]
);
  // odd-even transposition network: WIN layers sort WIN keys
  key_t lay [WIN+1][WIN];

  for (genvar i = 0; i < int'(WIN); i++) begin : g_in
    assign lay[0][i] = keys_in[i];
    assign keys_out[i] = lay[WIN][i];
  end

  for (genvar l = 0; l < int'(WIN); l++) begin : g_layer
    for (genvar i = 0; i < int'(WIN); i++) begin : g_cell
      if ((i % 2) == (l % 2) && (i + 1) < int'(WIN)) begin : g_lo
        assign lay[l+1][i] = (lay[l][i] <= lay[l][i+1]) ? lay[l][i] : lay[l][i+1];
      end else if (i > 0 && ((i - 1) % 2) == (l % 2)) begin : g_hi
        assign lay[l+1][i] = (lay[l][i-1] <= lay[l][i]) ? lay[l][i] : lay[l][i-1];
      end else begin : g_pass
        assign lay[l+1][i] = lay[l][i];
      end
    end
  end
endmodule

// File: rtl/impf_select.sv
module impf_select
  import impf_pkg::*;
#(
  parameter int unsigned WIN   = 9,
  parameter int unsigned CNT_W = $clog2(WIN + 1),
  parameter int unsigned SUM_W = PIX_W + $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s2_valid,
  input  key_t             s2_keys [WIN],
  input  logic [CNT_W-1:0] s2_cnt,
  input  logic [SUM_W-1:0] s2_sum,
  input  pix_t             s2_centre,
  input  logic             s2_noisy,
  output logic             o_valid,
  output pix_t             o_pix
);
  logic [CNT_W-1:0] mid_idx;
  key_t             sel_key;
  pix_t             repl;
  logic             use_mean;

  assign mid_idx  = (s2_cnt - CNT_W'(1)) >> 1;
  assign use_mean = (s2_cnt == '0);

  always_comb begin
    sel_key = s2_keys[0];
    for (int i = 0; i < int'(WIN); i++)
      if (CNT_W'(i) == mid_idx) sel_key = s2_keys[i];
  end

  always_comb begin
    if (!s2_noisy)     repl = s2_centre;
    else if (use_mean) repl = mean_div(32'(s2_sum), WIN);
    else               repl = sel_key[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) o_valid <= 1'b0;
    else     o_valid <= s2_valid;
  end

  always_ff @(posedge clk) o_pix <= repl;

  a_r2_clean_passes: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && !s2_noisy) |=> (o_valid && o_pix == $past(s2_centre)));
  a_r3_pick_is_clean: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && s2_noisy && !use_mean) |-> !sel_key[PIX_W]);
  a_r3_no_impulse_out: assert property (@(posedge clk) disable iff (rst)
    (s2_valid && s2_noisy && !use_mean) |=> !is_impulse(o_pix));
endmodule

// File: rtl/impulse_repair_filter.sv
module impulse_repair_filter
  import impf_pkg::*;
#(
  parameter int unsigned WIN    = 9,
  parameter int unsigned CENTRE = WIN / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 win_valid,
  input  logic [WIN*PIX_W-1:0] win_data,
  output logic                 pix_valid,
  output logic [PIX_W-1:0]     pix_out
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);
  localparam int unsigned SUM_W = PIX_W + $clog2(WIN);

  pix_t px [WIN];
  for (genvar g = 0; g < int'(WIN); g++) begin : g_unpack
    assign px[g] = win_data[g*PIX_W +: PIX_W];
  end

  // stage 1: detection, tagging, count and sum
  logic             s1_valid, s1_noisy;
  key_t             s1_keys [WIN];
  logic [CNT_W-1:0] s1_cnt;
  logic [SUM_W-1:0] s1_sum;
  pix_t             s1_centre;

  impf_detect #(.WIN(WIN), .CENTRE(CENTRE), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_detect (
    .clk(clk), .rst(rst), .v_in(win_valid), .px(px),
    .s1_valid(s1_valid), .s1_keys(s1_keys), .s1_cnt(s1_cnt),
    .s1_sum(s1_sum), .s1_centre(s1_centre), .s1_noisy(s1_noisy)
  );

  // stage 2: sort network, registered
  key_t sorted [WIN];
  impf_sort #(.WIN(WIN)) u_sort (.keys_in(s1_keys), .keys_out(sorted));

  logic             s2_valid, s2_noisy;
  key_t             s2_keys [WIN];
  logic [CNT_W-1:0] s2_cnt;
  logic [SUM_W-1:0] s2_sum;
  pix_t             s2_centre;

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(WIN); i++) s2_keys[i] <= sorted[i];
    s2_cnt    <= s1_cnt;
    s2_sum    <= s1_sum;
    s2_centre <= s1_centre;
    s2_noisy  <= s1_noisy;
  end

  for (genvar g = 0; g + 1 < int'(WIN); g++) begin : g_order_chk
    a_r3_sorted_order: assert property (@(posedge clk) disable iff (rst)
      s2_valid |-> s2_keys[g] <= s2_keys[g+1]);
  end

  // stage 3: decision and output register
  impf_select #(.WIN(WIN), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_select (
    .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_keys(s2_keys),
    .s2_cnt(s2_cnt), .s2_sum(s2_sum), .s2_centre(s2_centre),
    .s2_noisy(s2_noisy), .o_valid(pix_valid), .o_pix(pix_out)
  );

  // cycles since reset, saturating, bounds the latency check
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r6_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> pix_valid == $past(win_valid, 3));
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> !pix_valid);
endmodule

// File: tb/sim_impulse_repair_filter.sv
module sim_impulse_repair_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  // windows written {p8,p7,p6,p5,p4(centre),p3,p2,p1,p0}
  localparam logic [71:0] VW [NV] = '{
    {8'd90, 8'd80, 8'd70, 8'd60, 8'd50, 8'd40, 8'd30, 8'd20, 8'd10},
    {8'd255,8'd0,  8'd0,  8'd255,8'd1,  8'd255,8'd0,  8'd255,8'd0},
    {8'd0,  8'd0,  8'd0,  8'd0,  8'd254,8'd0,  8'd0,  8'd0,  8'd0},
    {8'd3,  8'd99, 8'd0,  8'd30, 8'd255,8'd7,  8'd255,8'd12, 8'd0},
    {8'd125,8'd175,8'd150,8'd75, 8'd0,  8'd25, 8'd50, 8'd200,8'd100},
    {8'd0,  8'd0,  8'd255,8'd20, 8'd255,8'd0,  8'd40, 8'd255,8'd0},
    {8'd255,8'd77, 8'd255,8'd255,8'd0,  8'd255,8'd255,8'd255,8'd255},
    {8'd1,  8'd0,  8'd9,  8'd5,  8'd255,8'd9,  8'd0,  8'd5,  8'd5},
    {8'd127,8'd255,8'd253,8'd2,  8'd0,  8'd128,8'd3,  8'd1,  8'd254},
    {8'd255,8'd0,  8'd255,8'd0,  8'd0,  8'd0,  8'd255,8'd0,  8'd255},
    {8'd255,8'd255,8'd255,8'd255,8'd255,8'd255,8'd255,8'd255,8'd255},
    {8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd0,  8'd0},
    {8'd255,8'd255,8'd255,8'd255,8'd0,  8'd255,8'd255,8'd255,8'd255},
    {8'd255,8'd255,8'd255,8'd255,8'd128,8'd0,  8'd0,  8'd0,  8'd0},
    {8'd0,  8'd0,  8'd0,  8'd0,  8'd255,8'd0,  8'd0,  8'd0,  8'd200}
  };
  localparam logic [7:0] VEXP [NV] = '{
    8'd50, 8'd1, 8'd254, 8'd12, 8'd100, 8'd20, 8'd77, 8'd5,
    8'd127, 8'd113, 8'd255, 8'd0, 8'd226, 8'd128, 8'd200
  };
  localparam logic [15:0] VTAG [NV] = '{
    "R2", "R1", "R1", "R3", "R4", "R4", "R3", "R4",
    "R3", "R5", "R5", "R5", "R5", "R2", "R3"
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        win_valid = 1'b0;
  logic [71:0] win_data = '0;
  logic        pix_valid;
  logic [7:0]  pix_out;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  impulse_repair_filter u0 (
    .clk(clk), .rst(rst), .win_valid(win_valid), .win_data(win_data),
    .pix_valid(pix_valid), .pix_out(pix_out)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pix_out actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pix_valid actual %0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // reset state (R7)
    repeat (2) @(negedge clk);
    check1("R7", pix_valid, 1'b0);
    rst = 1'b0;

    // table walk: one window, result checked three edges later (R1..R5)
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      win_data  = VW[k];
      win_valid = 1'b1;
      @(negedge clk);
      win_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check1("R6", pix_valid, 1'b1);
      check8(string'(VTAG[k]), pix_out, VEXP[k]);
    end

    // back-to-back stream, results in order three cycles behind (R6)
    for (int k = 0; k < NV + 3; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        check1("R6", pix_valid, 1'b1);
        check8("R6", pix_out, VEXP[k-3]);
      end else begin
        check1("R6", pix_valid, 1'b0);
      end
      if (k < NV) begin
        win_data  = VW[k];
        win_valid = 1'b1;
      end else begin
        win_valid = 1'b0;
      end
    end

    // noisy data without strobe yields nothing (R6)
    win_data = VW[3];
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check1("R6", pix_valid, 1'b0);
    end

    // reset with windows in flight (R7)
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      win_data  = VW[k];
      win_valid = 1'b1;
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check1("R7", pix_valid, 1'b0);
    win_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check1("R7", pix_valid, 1'b0);
    end

    // single window after reset still works (R3)
    win_data  = VW[8];
    win_valid = 1'b1;
    @(negedge clk);
    win_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check1("R6", pix_valid, 1'b1);
    check8("R3", pix_out, VEXP[8]);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule